// File: doc/BRIEF.md
# Multi-Accumulator Byte Processor

This block is a small 8-bit processor core. It works on a bank of byte-wide accumulators and one flat byte-addressed memory. Each opcode byte carries both the operation and the accumulator it acts on. The core steps through memory with a multi-cycle fetch sequence. It reads the opcode byte first. For load, store and jump-if-zero it then reads a two-byte address operand, and a load or store adds one more cycle for the data transfer.

The memory sits outside the core on a simple bus. The address and write strobe are registered, and read data is expected back combinationally for the address currently driven. Results leave the core in two ways: through memory writes, and through a byte-wide indicator register (the LED output) that the program sets or clears.

Top module: `acc8_core`

## Requirements
- R1: While reset is held and in the cycle after it is released, the LED output is 0, the write strobe is low and the bus address is 0. Every accumulator reads as 0 after reset.
- R2: Opcode bits [3:0] select the operation: 0 no-op, 1 load, 2 store, 3 jump-if-zero, 4 increment, 5 decrement, 6 show on LED, 7 blank LED. Bits [6:4] name the accumulator. Well-formed code keeps bit 7 at 0.
- R3: Four independent accumulators exist. Writing one leaves the others unchanged.
- R4: Accumulator selects 4 to 7 act on accumulators 0 to 3, because the top select bit is dropped.
- R5: An opcode with bit 7 set, or with an operation code of 8 to 15, is a one-byte no-op that changes no accumulator, the LED or memory.
- R6: The address operand follows the opcode low byte first. Only the low 4 bits of the second byte are used, which gives a 12-bit address.
- R7: A load copies the addressed byte into the selected accumulator. A store writes the selected accumulator to the addressed byte, and the write strobe is high for exactly one cycle.
- R8: Jump-if-zero continues at the operand address when the selected accumulator is 0. Otherwise it continues at the byte after the operand.
- R9: Increment and decrement wrap modulo 256.
- R10: Show copies the selected accumulator to the LED. Blank sets the LED to 0 whatever the select field holds. No other instruction changes the LED.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 12 | Registered memory address |
| mem_rdata | input | 8 | Read data for the current mem_addr, valid in the same cycle |
| mem_wdata | output | 8 | Registered store data |
| mem_we | output | 1 | Registered write strobe |
| led | output | 8 | Indicator register |

## Verification
The assertions assume that the memory returns the byte for the address driven in the same cycle. They also assume that reset is applied for at least one clock before the program runs. The bench memory is a combinational read array that is written on the clock edge while the strobe is high, so both assumptions hold throughout the run. The program holds only well-formed opcodes, apart from the deliberate bit-7 and high-operation bytes. It ends in a jump-to-self, so the core never fetches past the loaded code.

// File: rtl/acc8_pkg.sv
package acc8_pkg;

  typedef enum logic [2:0] {
    OP_NOP   = 3'd0,
    OP_LOAD  = 3'd1,
    OP_STORE = 3'd2,
    OP_JZ    = 3'd3,
    OP_INC   = 3'd4,
    OP_DEC   = 3'd5,
    OP_SHOW  = 3'd6,
    OP_BLANK = 3'd7
  } op_e;

  typedef enum logic [1:0] {
    ST_FETCH = 2'd0,
    ST_ALO   = 2'd1,
    ST_AHI   = 2'd2,
    ST_MEM   = 2'd3
  } state_e;

  typedef struct packed {
    op_e        op;
    logic [2:0] sel;
    logic       has_addr;
  } dec_t;

endpackage

// File: rtl/acc8_decode.sv
module acc8_decode
  import acc8_pkg::*;
(
  input  logic [7:0] code,
  output dec_t       dec
);

  always_comb begin
    dec.sel = code[6:4];
    // R5: top bit set or operation nibble above 7 -> no-op
    if (code[7] || code[3]) dec.op = OP_NOP;
    else                    dec.op = op_e'(code[2:0]);
    dec.has_addr = (dec.op == OP_LOAD) || (dec.op == OP_STORE) || (dec.op == OP_JZ);
  end

endmodule

// File: rtl/acc8_accbank.sv
module acc8_accbank #(
  parameter int DATA_W  = 8,
  parameter int NUM_ACC = 4,
  localparam int IDX_W  = (NUM_ACC > 1) ? $clog2(NUM_ACC) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data
);

  logic [DATA_W-1:0] acc_q  [NUM_ACC];
  logic [NUM_ACC-1:0] wr_vec;

  for (genvar i = 0; i < NUM_ACC; i++) begin : g_acc
    assign wr_vec[i] = wr_en && (wr_idx == IDX_W'(i));

    always_ff @(posedge clk) begin
      if (rst)            acc_q[i] <= '0;
      else if (wr_vec[i]) acc_q[i] <= wr_data;
    end

    AST_ACC_UNTOUCHED: assert property (@(posedge clk) disable iff (rst)
      !wr_vec[i] |=> $stable(acc_q[i])); // R3
  end

  assign rd_data = acc_q[rd_idx];

  AST_SINGLE_WRITE: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wr_vec)); // R3

endmodule

// File: rtl/acc8_core.sv
module acc8_core
  import acc8_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int ADDR_W  = 12,
  parameter int NUM_ACC = 4
) (
  input  logic              clk,
  input  logic              rst,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  output logic [DATA_W-1:0] led
);

  localparam int IDX_W = (NUM_ACC > 1) ? $clog2(NUM_ACC) : 1;
  localparam int HI_W  = ADDR_W - DATA_W;

  state_e            state_q;
  logic [ADDR_W-1:0] pc_q;
  logic [DATA_W-1:0] ir_q;
  logic [DATA_W-1:0] lo_q;

  dec_t dec_now, dec_ir, dec_cur;

  acc8_decode u_dec_now (.code(mem_rdata), .dec(dec_now));
  acc8_decode u_dec_ir  (.code(ir_q),      .dec(dec_ir));

  assign dec_cur = (state_q == ST_FETCH) ? dec_now : dec_ir;

  // R4: select aliases by keeping only the low index bits
  logic [IDX_W-1:0]  acc_idx;
  logic              acc_we;
  logic [DATA_W-1:0] acc_wdata, acc_rdata;
  logic [ADDR_W-1:0] target, pc_inc;

  assign acc_idx = dec_cur.sel[IDX_W-1:0];
  assign target  = {mem_rdata[HI_W-1:0], lo_q};   // R6
  assign pc_inc  = pc_q + 1'b1;

  always_comb begin
    acc_we    = 1'b0;
    acc_wdata = acc_rdata;
    if (state_q == ST_FETCH) begin
      if (dec_now.op == OP_INC) begin
        acc_we    = 1'b1;
        acc_wdata = acc_rdata + 1'b1;   // R9
      end else if (dec_now.op == OP_DEC) begin
        acc_we    = 1'b1;
        acc_wdata = acc_rdata - 1'b1;   // R9
      end
    end else if (state_q == ST_MEM && dec_ir.op == OP_LOAD) begin
      acc_we    = 1'b1;
      acc_wdata = mem_rdata;            // R7
    end
  end

  acc8_accbank #(.DATA_W(DATA_W), .NUM_ACC(NUM_ACC)) u_bank (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (acc_we),
    .wr_idx  (acc_idx),
    .wr_data (acc_wdata),
    .rd_idx  (acc_idx),
    .rd_data (acc_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_FETCH;
      pc_q      <= '0;
      ir_q      <= '0;
      lo_q      <= '0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      mem_we    <= 1'b0;
      led       <= '0;
    end else begin
      case (state_q)
        ST_FETCH: begin
          ir_q     <= mem_rdata;
          pc_q     <= pc_inc;
          mem_addr <= pc_inc;
          if (dec_now.has_addr) state_q <= ST_ALO;
          if (dec_now.op == OP_SHOW)  led <= acc_rdata;  // R10
          if (dec_now.op == OP_BLANK) led <= '0;         // R10
        end
        ST_ALO: begin
          lo_q     <= mem_rdata;
          pc_q     <= pc_inc;
          mem_addr <= pc_inc;
          state_q  <= ST_AHI;
        end
        ST_AHI: begin
          if (dec_ir.op == OP_JZ) begin
            state_q <= ST_FETCH;
            if (acc_rdata == '0) begin                    // R8
              pc_q     <= target;
              mem_addr <= target;
            end else begin
              pc_q     <= pc_inc;
              mem_addr <= pc_inc;
            end
          end else begin
            pc_q     <= pc_inc;
            mem_addr <= target;
            state_q  <= ST_MEM;
            if (dec_ir.op == OP_STORE) begin
              mem_we    <= 1'b1;
              mem_wdata <= acc_rdata;
            end
          end
        end
        default: begin
          mem_we   <= 1'b0;
          mem_addr <= pc_q;
          state_q  <= ST_FETCH;
        end
      endcase
    end
  end

  AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> !mem_we); // R7

  AST_XFER_ONLY: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_MEM) |-> (dec_ir.op == OP_LOAD || dec_ir.op == OP_STORE)); // R7

  AST_LED_SOURCE: assert property (@(posedge clk) disable iff (rst)
    !$stable(led) |-> ($past(state_q) == ST_FETCH)); // R10

  AST_JUMP_TAKEN: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_AHI && dec_ir.op == OP_JZ && acc_rdata == '0)
      |=> (mem_addr == $past(target))); // R8

endmodule

// File: tb/tb_acc8_core.sv
module tb_acc8_core;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] mem_addr;
  logic [7:0]  mem_rdata, mem_wdata, led;
  logic        mem_we;

  logic [7:0]  mem [4096];

  always #(CLK_PERIOD/2) clk = ~clk;

  assign mem_rdata = mem[mem_addr];
  always @(posedge clk) if (mem_we) mem[mem_addr] <= mem_wdata;

  acc8_core dut (
    .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .mem_wdata(mem_wdata), .mem_we(mem_we), .led(led)
  );

  int n_checks = 0;
  int n_fails  = 0;
  bit running  = 0;
  int loc      = 0;

  // scoreboard queues: kind (1 = store, 0 = LED), address, data, requirement
  bit          q_st  [$];
  logic [11:0] q_ad  [$];
  logic [7:0]  q_dt  [$];
  string       q_req [$];

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic org(input int a);  loc = a; endtask
  task automatic put(input logic [7:0] b); mem[loc] = b; loc++; endtask

  task automatic exp_led(input logic [7:0] v, input string req);
    q_st.push_back(1'b0); q_ad.push_back('0); q_dt.push_back(v); q_req.push_back(req);
  endtask
  task automatic exp_st(input logic [11:0] a, input logic [7:0] v, input string req);
    q_st.push_back(1'b1); q_ad.push_back(a); q_dt.push_back(v); q_req.push_back(req);
  endtask

  // monitor: pops one expected item for every observed store or LED change
  logic [7:0] prev_led = '0;
  always @(negedge clk) begin
    if (running) begin
      if (mem_we) begin
        if (q_st.size() == 0) check("unexpected store", {20'd0, mem_addr}, 32'hFFFF);
        else begin
          check({q_req[0], " store kind"}, {31'd0, q_st[0]}, 1);
          check({q_req[0], " store addr"}, {20'd0, mem_addr}, {20'd0, q_ad[0]});
          check({q_req[0], " store data"}, {24'd0, mem_wdata}, {24'd0, q_dt[0]});
          void'(q_st.pop_front()); void'(q_ad.pop_front());
          void'(q_dt.pop_front()); void'(q_req.pop_front());
        end
      end
      if (led !== prev_led) begin
        if (q_st.size() == 0) check("unexpected LED change R10", {24'd0, led}, {24'd0, prev_led});
        else begin
          check({q_req[0], " LED kind"}, {31'd0, q_st[0]}, 0);
          check({q_req[0], " LED value"}, {24'd0, led}, {24'd0, q_dt[0]});
          void'(q_st.pop_front()); void'(q_ad.pop_front());
          void'(q_dt.pop_front()); void'(q_req.pop_front());
        end
        prev_led = led;
      end
    end
  end

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
    mem[12'h800] = 8'h5A;
    mem[12'h801] = 8'hFF;

    // R1: accumulator 2 is zero after reset, so the jump skips a trap
    org(12'h000);
    put(8'h23); put(8'h08); put(8'h00);
    put(8'h24); put(8'h24); put(8'h26);   // trap: would show 02
    org(12'h008);
    put(8'h04); put(8'h06);               exp_led(8'h01, "R2 inc+show acc0");
    put(8'h15); put(8'h15); put(8'h16);   exp_led(8'hFE, "R9 dec wrap acc1 / R3");
    put(8'h37);                           exp_led(8'h00, "R10 blank");
    put(8'h21); put(8'h00); put(8'hF8);   // R6: hi byte F8 -> 0x800
    put(8'h66);                           exp_led(8'h5A, "R4 select 6 -> acc2 after R7 load");
    put(8'h52); put(8'h10); put(8'h08);   exp_st(12'h810, 8'hFE, "R7 store via select 5 (R4)");
    put(8'h84); put(8'h09); put(8'h2F);   // R5 no-ops
    put(8'h06);                           exp_led(8'h01, "R5 acc0 unchanged by no-ops");
    put(8'h31); put(8'h01); put(8'h08);   // load FF into acc3
    put(8'h34);                           // R9 wrap to 00
    put(8'h33); put(8'h40); put(8'h00);   // R8 taken jump
    put(8'h16);                           // trap
    org(12'h040);
    put(8'h03); put(8'h00); put(8'h07);   // R8 not taken (acc0 = 1)
    put(8'h36);                           exp_led(8'h00, "R8/R9 acc3 wrapped to zero");
    put(8'h32); put(8'h11); put(8'h08);   exp_st(12'h811, 8'h00, "R7 store acc3");
    put(8'h02); put(8'h12); put(8'h18);   exp_st(12'h812, 8'h01, "R6 upper bits ignored");
    put(8'h26);                           exp_led(8'h5A, "R3 acc2 held");
    put(8'h33); put(8'h4B); put(8'h00);   // halt: jump to self
    org(12'h700);
    put(8'h16);                           // trap for wrong R8 path

    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 LED at reset", {24'd0, led}, 0);
    check("R1 strobe at reset", {31'd0, mem_we}, 0);
    check("R1 address at reset", {20'd0, mem_addr}, 0);
    rst = 1'b0;
    running = 1'b1;

    begin : wait_loop
      for (int c = 0; c < 3000; c++) begin
        @(negedge clk);
        if (q_st.size() == 0) disable wait_loop;
      end
    end
    if (q_st.size() != 0) begin
      n_checks++; n_fails++;
      $display("FAIL watchdog: %0d expected items left, expected 0", q_st.size());
    end
    repeat (60) @(negedge clk);
    running = 1'b0;

    check("R7 memory 0x810", {24'd0, mem[12'h810]}, 32'hFE);
    check("R7 memory 0x811", {24'd0, mem[12'h811]}, 32'h00);
    check("R6 memory 0x812", {24'd0, mem[12'h812]}, 32'h01);
    check("R5 no extra store at 0x000", {24'd0, mem[12'h000]}, 32'h23);
    check("R10 final LED", {24'd0, led}, 32'h5A);

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

endmodule